// File: doc/BRIEF.md
# Two-Hand Clock Page Reclaimer

This block keeps a used bit, a dirty bit and a residency bit for every physical page in a fixed pool. It reclaims idle pages with a clock sweep driven by two hands. Each memory reference that reaches the block marks its page as used. A write reference also marks the page dirty. While sweeping is enabled, the leading hand (the tail) visits one page per cycle and clears that page's used bit. The trailing hand (the head) sits a programmable number of pages behind the tail. If a resident page is still unused when the head arrives, the head either pushes the page index into a free-page queue or, when the page is dirty, raises a writeback request for it instead.

On a page fault the allocate input takes the oldest index from the free queue. That page becomes resident again and counts as freshly used. When the queue is empty, the block answers a fault with a not-available flag. The block does not perform the disk transfer and does not edit any page table. It only raises a writeback request and waits for the completion strobe, and it only hands out page indices.

Top module: `page_reclaimer`

## Requirements
- R11: After reset every page is resident with its used and dirty bits clear, the tail hand is at page 0, the free queue is empty and no writeback is requested.
- R1: A reference (`refValid`) to any page sets that page's used bit at the next clock edge.
- R2: A reference with `refWrite` high also sets the page's dirty bit.
- R3: Each sweep step clears the used bit of the page under the tail hand and advances the tail by one, modulo the page count. The head hand is always page (tail − `gapPages`) modulo the page count, using the current value of `gapPages`.
- R4: On a sweep step the head frees its page only if the page is resident, clean and unused, and no reference to that page arrives in the same cycle. Freeing pushes the index into the free queue and makes the page non-resident. Non-resident pages and used pages are passed over.
- R5: When the head reaches a resident, unused, dirty page and no writeback is pending, it raises `wbReq` with that page on `wbPage` and does not free it. Both outputs hold until `wbDone`. While a writeback is pending, other dirty pages are passed over.
- R6: If the head would free a page but the free queue is full, the sweep stalls: neither hand moves and no used bit is cleared.
- R7: `wbDone` while a writeback is pending clears that page's dirty bit and drops `wbReq`. The page can then be freed on a later visit of the head if it is still unused.
- R8: When a reference and the tail's clear hit the same page in the same cycle, the used bit ends up set.
- R9: `allocReq` on a non-empty queue raises `allocGrant` in the same cycle with the oldest queued index on `allocPage`. At the clock edge that index leaves the queue and its page becomes resident with used set and dirty clear.
- R10: `allocReq` on an empty queue raises `allocNone` instead of `allocGrant` and changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sweepEn | input | 1 | Allows one sweep step per cycle |
| gapPages | input | log2(NUM_PAGES) | Distance of the head behind the tail |
| refValid | input | 1 | A memory reference occurs this cycle |
| refPage | input | log2(NUM_PAGES) | Page touched by the reference |
| refWrite | input | 1 | The reference is a write |
| allocReq | input | 1 | Page fault wants a free page |
| allocGrant | output | 1 | A free page is handed out this cycle |
| allocNone | output | 1 | The fault found the free queue empty |
| allocPage | output | log2(NUM_PAGES) | Index of the page handed out |
| wbReq | output | 1 | Writeback pending for `wbPage` |
| wbPage | output | log2(NUM_PAGES) | Page awaiting writeback |
| wbDone | input | 1 | The pending writeback has finished |

## Verification
Two functions can land on the same page in one cycle: the tail's clear of a used bit and a reference that sets it. A further collision exists between the head's free decision and a reference to the head page. The bench provokes the first by sending a reference to the page under the tail on every sweep step, using the tail position it predicts itself. It then keeps sweeping and allocating. If the clear won, the head would free the page and the allocation order would differ from the prediction, so the collision is judged by the indices handed out later and by the absence of unexpected grants. Pops and pushes in the same cycle, and a writeback completion that arrives together with a new write to the same page, are exercised the same way.

// File: rtl/reclaim_pkg.sv
package reclaim_pkg;
  // Strobes from the sweep control to the page-bit datapath.
  typedef struct packed {
    logic clrUsed;  // tail clears the used bit of its page
    logic freeEn;   // head page leaves the resident set
    logic allocEn;  // popped page rejoins the resident set
    logic wbClear;  // writeback finished, clear dirty
  } bitStrobe_t;
endpackage

// File: rtl/reclaim_freeq.sv
module reclaim_freeq #(
  parameter int DEPTH = 4,
  parameter int IW    = 3
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          push,
  input  logic [IW-1:0] pushData,
  input  logic          pop,
  output logic [IW-1:0] popData,
  output logic          empty,
  output logic          full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [IW-1:0] slots [DEPTH];
  logic [PW-1:0] rdPtr, wrPtr;
  logic [CW-1:0] count;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign popData = slots[rdPtr];

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
    end else begin
      if (push) begin
        slots[wrPtr] <= pushData;
        wrPtr        <= bump(wrPtr);
      end
      if (pop) rdPtr <= bump(rdPtr);
      if (push && !pop) count <= count + 1'b1;
      else if (pop && !push) count <= count - 1'b1;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    full |-> !push);  // R6
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    empty |-> !pop);  // R10
endmodule

// File: rtl/reclaim_pagebits.sv
module reclaim_pagebits
  import reclaim_pkg::*;
#(
  parameter int NUM_PAGES = 8,
  parameter int IW        = 3
) (
  input  logic          clk,
  input  logic          rstN,
  input  bitStrobe_t    strobe,
  input  logic [IW-1:0] tailIdx,
  input  logic [IW-1:0] headIdx,
  input  logic [IW-1:0] allocIdx,
  input  logic [IW-1:0] wbIdx,
  input  logic          refValid,
  input  logic [IW-1:0] refPage,
  input  logic          refWrite,
  output logic          headUsed,
  output logic          headDirty,
  output logic          headRes
);
  logic [NUM_PAGES-1:0] usedQ, dirtyQ, resQ;

  for (genvar i = 0; i < NUM_PAGES; i++) begin : g_page
    always_ff @(posedge clk) begin
      if (!rstN) begin
        usedQ[i]  <= 1'b0;
        dirtyQ[i] <= 1'b0;
        resQ[i]   <= 1'b1;
      end else begin
        if (strobe.clrUsed && tailIdx == IW'(i)) usedQ[i] <= 1'b0;
        if (strobe.wbClear && wbIdx == IW'(i)) dirtyQ[i] <= 1'b0;
        if (strobe.freeEn && headIdx == IW'(i)) resQ[i] <= 1'b0;
        if (strobe.allocEn && allocIdx == IW'(i)) begin
          usedQ[i]  <= 1'b1;
          dirtyQ[i] <= 1'b0;
          resQ[i]   <= 1'b1;
        end
        // a reference always wins over the tail clear
        if (refValid && refPage == IW'(i)) begin
          usedQ[i] <= 1'b1;
          if (refWrite) dirtyQ[i] <= 1'b1;
        end
      end
    end
  end

  assign headUsed  = usedQ[headIdx];
  assign headDirty = dirtyQ[headIdx];
  assign headRes   = resQ[headIdx];

  AST_REF_SETS_USED: assert property (@(posedge clk) disable iff (!rstN)
    refValid |=> usedQ[$past(refPage)]);  // R1
  AST_WRITE_SETS_DIRTY: assert property (@(posedge clk) disable iff (!rstN)
    (refValid && refWrite) |=> dirtyQ[$past(refPage)]);  // R2
  AST_CLEAR_LOSES: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.clrUsed && refValid && refPage == tailIdx) |=> usedQ[$past(tailIdx)]);  // R8
endmodule

// File: rtl/reclaim_ctrl.sv
module reclaim_ctrl
  import reclaim_pkg::*;
#(
  parameter int NUM_PAGES = 8,
  parameter int IW        = 3
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          sweepEn,
  input  logic [IW-1:0] gapPages,
  input  logic          refValid,
  input  logic [IW-1:0] refPage,
  input  logic          allocReq,
  input  logic          wbDone,
  input  logic          headUsed,
  input  logic          headDirty,
  input  logic          headRes,
  input  logic          qEmpty,
  input  logic          qFull,
  output bitStrobe_t    strobe,
  output logic [IW-1:0] tailIdx,
  output logic [IW-1:0] headIdx,
  output logic          qPush,
  output logic          qPop,
  output logic          wbReq,
  output logic [IW-1:0] wbPage
);
  logic [IW-1:0] tailQ, wbPageQ;
  logic          wbBusyQ;
  logic          refHit, victim, freeNow, stall, step, wbNow;

  // head trails tail by gapPages, wrapping over the page count
  always_comb begin
    if (tailQ >= gapPages) headIdx = tailQ - gapPages;
    else headIdx = IW'(NUM_PAGES) - (gapPages - tailQ);
  end

  assign tailIdx = tailQ;
  assign refHit  = refValid && (refPage == headIdx);
  assign victim  = sweepEn && headRes && !headUsed && !refHit;
  assign freeNow = victim && !headDirty;
  assign stall   = freeNow && qFull;
  assign step    = sweepEn && !stall;
  assign wbNow   = victim && headDirty && !wbBusyQ;

  assign qPush = freeNow && !qFull;
  assign qPop  = allocReq && !qEmpty;

  always_comb begin
    strobe.clrUsed = step;
    strobe.freeEn  = qPush;
    strobe.allocEn = qPop;
    strobe.wbClear = wbDone && wbBusyQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tailQ   <= '0;
      wbBusyQ <= 1'b0;
      wbPageQ <= '0;
    end else begin
      if (step) tailQ <= (tailQ == IW'(NUM_PAGES - 1)) ? '0 : tailQ + 1'b1;
      if (strobe.wbClear) wbBusyQ <= 1'b0;
      if (wbNow) begin
        wbBusyQ <= 1'b1;
        wbPageQ <= headIdx;
      end
    end
  end

  assign wbReq  = wbBusyQ;
  assign wbPage = wbPageQ;

  AST_TAIL_ADVANCE: assert property (@(posedge clk) disable iff (!rstN)
    step |=> tailQ == (($past(tailQ) == IW'(NUM_PAGES - 1)) ? '0 : $past(tailQ) + 1'b1));  // R3
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (sweepEn && qFull && freeNow) |=> $stable(tailQ));  // R6
  AST_WB_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (wbBusyQ && !wbDone) |=> (wbBusyQ && $stable(wbPageQ)));  // R5
  AST_WB_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    (wbBusyQ && wbDone) |=> !wbBusyQ);  // R7
endmodule

// File: rtl/page_reclaimer.sv
module page_reclaimer
  import reclaim_pkg::*;
#(
  parameter int NUM_PAGES  = 8,
  parameter int FREE_DEPTH = 4,
  localparam int IW = $clog2(NUM_PAGES)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          sweepEn,
  input  logic [IW-1:0] gapPages,
  input  logic          refValid,
  input  logic [IW-1:0] refPage,
  input  logic          refWrite,
  input  logic          allocReq,
  output logic          allocGrant,
  output logic          allocNone,
  output logic [IW-1:0] allocPage,
  output logic          wbReq,
  output logic [IW-1:0] wbPage,
  input  logic          wbDone
);
  bitStrobe_t    strobe;
  logic [IW-1:0] tailIdx, headIdx, popData;
  logic          headUsed, headDirty, headRes;
  logic          qEmpty, qFull, qPush, qPop;

  reclaim_ctrl #(.NUM_PAGES(NUM_PAGES), .IW(IW)) u_ctrl (
    .clk(clk), .rstN(rstN), .sweepEn(sweepEn), .gapPages(gapPages),
    .refValid(refValid), .refPage(refPage), .allocReq(allocReq),
    .wbDone(wbDone), .headUsed(headUsed), .headDirty(headDirty),
    .headRes(headRes), .qEmpty(qEmpty), .qFull(qFull), .strobe(strobe),
    .tailIdx(tailIdx), .headIdx(headIdx), .qPush(qPush), .qPop(qPop),
    .wbReq(wbReq), .wbPage(wbPage)
  );

  reclaim_pagebits #(.NUM_PAGES(NUM_PAGES), .IW(IW)) u_bits (
    .clk(clk), .rstN(rstN), .strobe(strobe), .tailIdx(tailIdx),
    .headIdx(headIdx), .allocIdx(popData), .wbIdx(wbPage),
    .refValid(refValid), .refPage(refPage), .refWrite(refWrite),
    .headUsed(headUsed), .headDirty(headDirty), .headRes(headRes)
  );

  reclaim_freeq #(.DEPTH(FREE_DEPTH), .IW(IW)) u_freeq (
    .clk(clk), .rstN(rstN), .push(qPush), .pushData(headIdx),
    .pop(qPop), .popData(popData), .empty(qEmpty), .full(qFull)
  );

  assign allocGrant = qPop;
  assign allocNone  = allocReq && qEmpty;
  assign allocPage  = popData;
endmodule

// File: tb/page_reclaimer_tb.sv
module page_reclaimer_tb;
  localparam int NP = 8;
  localparam int DEPTH = 4;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          sweepEn = 1'b0, refValid = 1'b0, refWrite = 1'b0;
  logic          allocReq = 1'b0, wbDone = 1'b0;
  logic [IW-1:0] gapPages = 3'd2, refPage = '0;
  logic          allocGrant, allocNone, wbReq;
  logic [IW-1:0] allocPage, wbPage;

  int checks = 0;
  int errors = 0;

  // bench expectation state, built from the requirements
  bit mUsed [NP];
  bit mDirty[NP];
  bit mRes  [NP];
  int mTail;
  bit mWbBusy;
  int mWbPage;
  int mq[$];

  always #2 clk = ~clk;

  page_reclaimer #(.NUM_PAGES(NP), .FREE_DEPTH(DEPTH)) u_dut (
    .clk(clk), .rstN(rstN), .sweepEn(sweepEn), .gapPages(gapPages),
    .refValid(refValid), .refPage(refPage), .refWrite(refWrite),
    .allocReq(allocReq), .allocGrant(allocGrant), .allocNone(allocNone),
    .allocPage(allocPage), .wbReq(wbReq), .wbPage(wbPage), .wbDone(wbDone)
  );

  function automatic void modelReset();
    for (int i = 0; i < NP; i++) begin
      mUsed[i] = 0; mDirty[i] = 0; mRes[i] = 1;
    end
    mTail = 0; mWbBusy = 0; mWbPage = 0;
    mq.delete();
  endfunction

  function automatic int headOf();
    return (mTail + NP - int'(gapPages)) % NP;
  endfunction

  function automatic void modelUpdate();
    int h, ap;
    bit victim, freeNow, stall, step, wbNow, popNow;
    h       = headOf();
    victim  = sweepEn && mRes[h] && !mUsed[h] && !(refValid && int'(refPage) == h);
    freeNow = victim && !mDirty[h];
    wbNow   = victim && mDirty[h] && !mWbBusy;
    stall   = freeNow && (mq.size() == DEPTH);
    step    = sweepEn && !stall;
    popNow  = allocReq && (mq.size() > 0);
    ap      = popNow ? mq[0] : 0;
    if (step) mUsed[mTail] = 0;
    if (wbDone && mWbBusy) begin mDirty[mWbPage] = 0; mWbBusy = 0; end
    if (popNow) begin
      void'(mq.pop_front());
      mRes[ap] = 1; mUsed[ap] = 1; mDirty[ap] = 0;
    end
    if (freeNow && !stall) begin mq.push_back(h); mRes[h] = 0; end
    if (wbNow) begin mWbBusy = 1; mWbPage = h; end
    if (refValid) begin
      mUsed[refPage] = 1;
      if (refWrite) mDirty[refPage] = 1;
    end
    if (step) mTail = (mTail + 1) % NP;
  endfunction

  task automatic idle();
    sweepEn = 0; refValid = 0; refWrite = 0; allocReq = 0; wbDone = 0;
  endtask

  // compare outputs with the prediction, then advance one clock
  task automatic cyc(input string tag);
    bit eG, eN, eW;
    int eP, eWp;
    #1;
    eG  = allocReq && (mq.size() > 0);
    eN  = allocReq && (mq.size() == 0);
    eP  = eG ? mq[0] : int'(allocPage);
    eW  = mWbBusy;
    eWp = eW ? mWbPage : int'(wbPage);
    checks++;
    if (allocGrant !== eG || allocNone !== eN || int'(allocPage) != eP ||
        wbReq !== eW || int'(wbPage) != eWp) begin
      errors++;
      $display("FAIL %s grant/none/page/wb/wbPage actual %0d %0d %0d %0d %0d expected %0d %0d %0d %0d %0d",
               tag, allocGrant, allocNone, allocPage, wbReq, wbPage, eG, eN, eP, eW, eWp);
    end
    @(posedge clk);
    modelUpdate();
    @(negedge clk);
  endtask

  task automatic tReset();
    idle();
    cyc("R11");                // no grant, no writeback after reset
    allocReq = 1; cyc("R10");  // empty queue answers not-available
    idle(); cyc("R11");
  endtask

  task automatic tSweepFree();
    gapPages = 3'd2;
    refValid = 1; refPage = 3'd7; cyc("R1");
    refPage = 3'd0; cyc("R1");
    idle();
    for (int k = 0; k < 5; k++) begin sweepEn = 1; cyc("R4"); end
    idle();
  endtask

  task automatic tStall();
    for (int k = 0; k < 3; k++) begin sweepEn = 1; cyc("R6"); end
    idle();
    for (int k = 0; k < DEPTH; k++) begin allocReq = 1; cyc("R9"); end
    allocReq = 1; cyc("R10");
    idle();
    for (int k = 0; k < 3; k++) begin sweepEn = 1; cyc("R6"); end
    idle();
    allocReq = 1; cyc("R9");
    idle();
  endtask

  task automatic tDirty();
    refValid = 1; refWrite = 1;
    refPage = 3'd5; cyc("R2");
    refPage = 3'd6; cyc("R2");
    idle();
    for (int k = 0; k < 24; k++) begin
      sweepEn = 1; allocReq = (k % 2 == 1); cyc("R5");
    end
    idle();
    wbDone = 1; refValid = 1; refWrite = 1; refPage = wbPage; cyc("R7");
    idle();
    for (int k = 0; k < 30; k++) begin
      sweepEn = 1; allocReq = (k % 3 == 2); wbDone = (k % 7 == 6); cyc("R7");
    end
    idle();
  endtask

  task automatic tCollide();
    for (int k = 0; k < 12; k++) begin
      sweepEn = 1; refValid = 1; refWrite = 0; refPage = IW'(mTail);
      allocReq = (k % 2 == 0);
      cyc("R8");
    end
    idle();
    for (int k = 0; k < 20; k++) begin
      sweepEn = 1; allocReq = (k % 2 == 0); cyc("R8");
    end
    idle();
  endtask

  task automatic tGap();
    gapPages = 3'd5;
    for (int k = 0; k < 20; k++) begin
      sweepEn = 1; allocReq = (k % 2 == 0);
      refValid = (k % 5 == 0); refPage = IW'(k % NP); cyc("R3");
    end
    gapPages = 3'd0;
    for (int k = 0; k < 20; k++) begin
      sweepEn = 1; allocReq = (k % 3 == 0); refValid = 0; wbDone = (k % 4 == 0);
      cyc("R3");
    end
    gapPages = 3'd7;
    for (int k = 0; k < 20; k++) begin
      sweepEn = 1; allocReq = 1; refValid = 1; refWrite = (k % 2 == 0);
      refPage = IW'((k * 3) % NP); wbDone = (k % 5 == 4); cyc("R4");
    end
    idle();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rstN = 1;
    modelReset();
    tReset();
    tSweepFree();
    tStall();
    tDirty();
    tCollide();
    tGap();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule